// File: doc/BRIEF.md
# Video Memory Block-Copy DMA

This block moves a run of bytes from anywhere in a 16-bit address space into the video memory window. Software loads a source address, a destination address and then a length/mode value through a byte-wide register port. The write of the length/mode value starts the copy. The engine then masters a simple request/grant memory port. For every byte it performs one read, holds the byte in an internal register, and then performs one write.

The destination is always forced into a 16-byte-aligned slot of an 8 KiB window based at 0x8000. The source is likewise aligned to 16 bytes. Lengths are given in 16-byte blocks. While the copy runs, `busy` is high and the length/mode register reads back the value that started the copy. When the last byte has been written, `done` pulses and the same register reads back 0xFF.

Top module: `vram_copy_dma`

## Requirements
- R1: Register offsets are 0 = source high, 1 = source low, 2 = destination high, 3 = destination low, 4 = length/mode. Offsets 0 to 3 read back the byte last written to them. The write destination base is (({dst_high,dst_low}) AND 0x1FF0) + 0x8000.
- R2: Bits 3:0 of the source address are ignored, so the source base is {src_high,src_low} with its low four bits cleared.
- R3: Writing value V to offset 4 copies (V[6:0] + 1) × 16 bytes, which gives 16 to 2048 bytes.
- R4: Byte i of a transfer is read from source base + i and then written to destination base + i, in increasing i, with 16-bit wraparound. Each write carries the byte returned by the read just before it.
- R5: A write to offset 4 while idle starts a transfer. `busy` is high from the clock edge that captures the write until the edge that completes the last write, and a new start is accepted as soon as `busy` is low.
- R6: A write to offset 4 while `busy` is high is ignored. The transfer keeps its original length and the status value does not change. This also holds when that write lands in the cycle that completes the last byte.
- R7: Offset 4 reads the starting value V, including bit 7, while a transfer runs. It reads 0xFF after completion. `done` is high for exactly one cycle per transfer.
- R8: Bit 7 of the starting value selects a mode that is only recorded. Both modes perform the same immediate copy.
- R9: An active-low synchronous reset returns the block to idle with `busy` low and every register, status included, reading 0x00. This also applies in the middle of a transfer.
- R10: `mem_req` is held with a stable address and direction until `mem_gnt` is sampled high. A read's data is taken from `mem_rdata` in the granted cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for both read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access, 0 = read access |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in a granted read cycle |
| mem_gnt | input | 1 | Grant; the pending access completes in this cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when the last byte is written |

## Verification
The two functions that can meet in one cycle are the ignored control write and transfer completion. The rule that a busy engine drops control writes must not keep the completion status from becoming 0xFF, and it must not let the write slip through as a new start once the engine turns idle. The bench grants every access so that timing is deterministic. It waits for the write of the final byte to be on the bus and drives a control write in that same cycle. It then checks that `busy` falls, that the status reads 0xFF, and that no further memory request appears. A separate test makes a busy-time write under random grant stalls and checks that the byte count and the status both keep their original values.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam int AW       = 16;
  localparam int DW       = 8;
  localparam int LENF_W   = 7;
  localparam int BLK_LOG2 = 4;
  localparam int CNT_W    = LENF_W + BLK_LOG2 + 1;
  localparam int RA_W     = 3;

  localparam logic [AW-1:0] DST_MASK = 16'h1FF0;
  localparam logic [AW-1:0] DST_BASE = 16'h8000;
  localparam logic [DW-1:0] STAT_DONE = '1;

  localparam logic [RA_W-1:0] RA_SRC_HI = 3'd0;
  localparam logic [RA_W-1:0] RA_SRC_LO = 3'd1;
  localparam logic [RA_W-1:0] RA_DST_HI = 3'd2;
  localparam logic [RA_W-1:0] RA_DST_LO = 3'd3;
  localparam logic [RA_W-1:0] RA_CTRL   = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} vdma_state_e;

  function automatic logic [AW-1:0] form_dst(input logic [AW-1:0] raw);
    return (raw & DST_MASK) + DST_BASE;
  endfunction

  function automatic logic [AW-1:0] align_src(input logic [AW-1:0] raw);
    return {raw[AW-1:BLK_LOG2], {BLK_LOG2{1'b0}}};
  endfunction

  function automatic logic [CNT_W-1:0] len_bytes(input logic [LENF_W-1:0] f);
    return (CNT_W'(f) + CNT_W'(1)) << BLK_LOG2;
  endfunction
endpackage

// File: rtl/vdma_regs.sv
module vdma_regs
  import vdma_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [RA_W-1:0] addr,
  input  logic [DW-1:0]   wdata,
  input  logic            busy,
  input  logic            done,
  output logic [AW-1:0]   src_raw,
  output logic [AW-1:0]   dst_raw,
  output logic [DW-1:0]   rdata,
  output logic            start,
  output logic [LENF_W-1:0] len_field
);
  logic [DW-1:0] src_hi_q, src_lo_q, dst_hi_q, dst_lo_q, stat_q;
  logic ctrl_wr;

  assign ctrl_wr   = we && (addr == RA_CTRL);
  assign start     = ctrl_wr && !busy;
  assign len_field = wdata[LENF_W-1:0];
  assign src_raw   = {src_hi_q, src_lo_q};
  assign dst_raw   = {dst_hi_q, dst_lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_hi_q <= '0;
      src_lo_q <= '0;
      dst_hi_q <= '0;
      dst_lo_q <= '0;
      stat_q   <= '0;
    end else begin
      if (we) begin
        case (addr)
          RA_SRC_HI: src_hi_q <= wdata;
          RA_SRC_LO: src_lo_q <= wdata;
          RA_DST_HI: dst_hi_q <= wdata;
          RA_DST_LO: dst_lo_q <= wdata;
          default:   ;
        endcase
      end
      if (start)     stat_q <= wdata;
      else if (done) stat_q <= STAT_DONE;
    end
  end

  always_comb begin
    case (addr)
      RA_SRC_HI: rdata = src_hi_q;
      RA_SRC_LO: rdata = src_lo_q;
      RA_DST_HI: rdata = dst_hi_q;
      RA_DST_LO: rdata = dst_lo_q;
      RA_CTRL:   rdata = stat_q;
      default:   rdata = '0;
    endcase
  end

  // R6: a control write while busy leaves the status alone unless completion lands
  a_r6_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_wr && !done) |=> $stable(stat_q));
  // R7: completion leaves the all-ones status
  a_r7_done_status: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (stat_q == STAT_DONE));
endmodule

// File: rtl/vdma_seq.sv
module vdma_seq
  import vdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    src_base,
  input  logic [AW-1:0]    dst_base,
  input  logic [CNT_W-1:0] nbytes,
  input  logic             mem_gnt,
  input  logic [DW-1:0]    mem_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             busy,
  output logic             done
);
  vdma_state_e      state_q;
  logic [AW-1:0]    src_q, dst_q;
  logic [CNT_W-1:0] idx_q, last_q;
  logic [DW-1:0]    byte_q;
  logic             last_hit;
  logic             rd_fire;

  assign last_hit  = (idx_q == last_q);
  assign mem_req   = (state_q != S_IDLE);
  assign mem_we    = (state_q == S_WRITE);
  assign mem_addr  = mem_we ? (dst_q + AW'(idx_q)) : (src_q + AW'(idx_q));
  assign mem_wdata = byte_q;
  assign busy      = mem_req;
  assign done      = (state_q == S_WRITE) && mem_gnt && last_hit;
  assign rd_fire   = (state_q == S_READ) && mem_gnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      byte_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          src_q   <= src_base;
          dst_q   <= dst_base;
          last_q  <= nbytes - CNT_W'(1);
          idx_q   <= '0;
          state_q <= S_READ;
        end
        S_READ: if (mem_gnt) begin
          byte_q  <= mem_rdata;
          state_q <= S_WRITE;
        end
        S_WRITE: if (mem_gnt) begin
          if (last_hit) state_q <= S_IDLE;
          else begin
            idx_q   <= idx_q + CNT_W'(1);
            state_q <= S_READ;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R4: a granted read is followed by a write of that very byte
  a_r4_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> (mem_req && mem_we && mem_wdata == $past(mem_rdata)));
  // R10: an ungranted access holds its address and direction
  a_r10_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R5: busy drops right after the final write
  a_r5_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R5: a start out of idle raises busy
  a_r5_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !mem_we));
endmodule

// File: rtl/vram_copy_dma.sv
module vram_copy_dma
  import vdma_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [15:0]     mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata,
  input  logic            mem_gnt,
  output logic            busy,
  output logic            done
);
  logic [AW-1:0]     src_raw, dst_raw;
  logic              start;
  logic [LENF_W-1:0] len_field;

  vdma_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .busy      (busy),
    .done      (done),
    .src_raw   (src_raw),
    .dst_raw   (dst_raw),
    .rdata     (reg_rdata),
    .start     (start),
    .len_field (len_field)
  );

  vdma_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .src_base  (align_src(src_raw)),
    .dst_base  (form_dst(dst_raw)),
    .nbytes    (len_bytes(len_field)),
    .mem_gnt   (mem_gnt),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .done      (done)
  );

  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/tb_vram_copy_dma.sv
module tb_vram_copy_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        mem_req, mem_we, busy, done;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_gnt = 1'b0;

  int tests = 0, fails = 0;
  int wr_cnt = 0, bus_err = 0, done_cnt = 0;
  logic [15:0] exp_src = 16'h0, exp_dst = 16'h0;
  logic        stall_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  vram_copy_dma dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_gnt(mem_gnt), .busy(busy), .done(done)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  assign mem_rdata = pat(mem_addr);

  // bus monitor and grant driver
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_gnt) begin
      if (mem_we) begin
        if (mem_addr !== exp_dst + 16'(wr_cnt) || mem_wdata !== pat(exp_src + 16'(wr_cnt)))
          bus_err++;
        wr_cnt++;
      end else if (mem_addr !== exp_src + 16'(wr_cnt)) begin
        bus_err++;
      end
    end
    if (rst_n && done) done_cnt++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_gnt <= stall_en ? lfsr[0] : 1'b1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] s, input logic [15:0] d);
    reg_write(3'd0, s[15:8]);
    reg_write(3'd1, s[7:0]);
    reg_write(3'd2, d[15:8]);
    reg_write(3'd3, d[7:0]);
    exp_src = {s[15:4], 4'h0};
    exp_dst = (d & 16'h1FF0) + 16'h8000;
    wr_cnt = 0; bus_err = 0; done_cnt = 0;
  endtask

  task automatic run_copy(input string tag, input logic [15:0] s, input logic [15:0] d,
                          input logic [7:0] v);
    logic [7:0] r;
    setup(s, d);
    reg_write(3'd4, v);
    chk({tag, " R5 busy after start"}, busy, 1);
    reg_read(3'd4, r);
    chk({tag, " R7 status while running"}, r, v);
    wait_idle();
    chk({tag, " R3 byte count"}, wr_cnt, (v[6:0] + 1) * 16);
    chk({tag, " R4 R1 R2 addresses and data"}, bus_err, 0);
    chk({tag, " R7 one done pulse"}, done_cnt, 1);
    reg_read(3'd4, r);
    chk({tag, " R7 status 0xFF"}, r, 8'hFF);
  endtask

  task automatic t_reset();
    logic [7:0] r;
    chk("R9 busy low after reset", busy, 0);
    chk("R9 no request after reset", mem_req, 0);
    for (int a = 0; a < 5; a++) begin
      reg_read(3'(a), r);
      chk("R9 register zero after reset", r, 0);
    end
  endtask

  task automatic t_regs();
    logic [7:0] r;
    setup(16'h1234, 16'hE05F);
    reg_read(3'd0, r); chk("R1 src high readback", r, 8'h12);
    reg_read(3'd1, r); chk("R1 src low readback", r, 8'h34);
    reg_read(3'd2, r); chk("R1 dst high readback", r, 8'hE0);
    reg_read(3'd3, r); chk("R1 dst low readback", r, 8'h5F);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] r;
    stall_en = 1'b1;
    setup(16'h4321, 16'h0123);
    reg_write(3'd4, 8'h01);
    repeat (5) @(negedge clk);
    reg_write(3'd4, 8'h85);
    reg_read(3'd4, r);
    chk("R6 status kept after busy write", r, 8'h01);
    wait_idle();
    chk("R6 original length kept", wr_cnt, 32);
    chk("R6 data intact", bus_err, 0);
    stall_en = 1'b0;
  endtask

  task automatic t_coincide();
    logic [7:0] r;
    int guard = 0;
    setup(16'h2000, 16'h0040);
    reg_write(3'd4, 8'h00);
    @(negedge clk);
    while (!(mem_req && mem_we && mem_addr == exp_dst + 16'd15) && guard < 100) begin
      @(negedge clk); guard++;
    end
    reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h03;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R6 busy falls despite coinciding write", busy, 0);
    reg_read(3'd4, r);
    chk("R6 R7 status 0xFF after coinciding write", r, 8'hFF);
    repeat (4) @(negedge clk);
    chk("R6 no restart from coinciding write", mem_req, 0);
    chk("R6 coinciding byte count", wr_cnt, 16);
  endtask

  task automatic t_mid_reset();
    logic [7:0] r;
    setup(16'h3000, 16'h0000);
    reg_write(3'd4, 8'h10);
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R9 busy cleared by reset mid-run", busy, 0);
    reg_read(3'd4, r);
    chk("R9 status cleared by reset mid-run", r, 0);
    reg_read(3'd1, r);
    chk("R9 source cleared by reset mid-run", r, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    run_copy("basic", 16'h1234, 16'hE05F, 8'h00);
    run_copy("R8 mode bit set", 16'h0ABC, 16'h1FF0, 8'h82);
    run_copy("R4 source wrap", 16'hFFF7, 16'h0100, 8'h01);
    stall_en = 1'b1;
    run_copy("R10 stalled max length", 16'h5000, 16'h0800, 8'h7F);
    stall_en = 1'b0;
    t_busy_ignore();
    t_coincide();
    run_copy("R5 restart after coincide", 16'h6000, 16'h0200, 8'h00);
    t_mid_reset();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule